// File: doc/BRIEF.md
# Fast-settling second-order sinc decimator

This block turns a 1-bit delta-sigma bit stream into multi-bit result words. It uses a modified second-order sinc response, ((1−z^−OSR)/(1−z^−1))^2 · (1+z^−2·OSR). Two running sums work at the modulator clock. The stream is then decimated by the oversampling ratio OSR. Two differences work at the output rate, and a final term adds the sinc² result from two output samples earlier. A step in input density reaches its final value after four output words. That makes the filter fit fast overcurrent detection, where plain sinc³ needs three output periods of history at a lower resolution per unit time.

The modulator changes its data on the falling edge of the clock, so the block samples the bit on the rising edge. The ratio is a runtime input and is clamped to the range 16 to 256. When the clamped ratio changes, the filter restarts from empty. Each result comes with a one-cycle strobe and a flag. The flag says whether the word's whole history lies inside the current run.

Top module: `sincfast_decim`

## Requirements
- R1: While rst_n is low, and for the first two rising edges after it rises, valid_o, settled_o and dout_o are 0. Reset assertion takes effect without a clock. The third rising edge after release loads the ratio and discards its bit, as in R8.
- R2: The active ratio is osr_i clamped to the range 16 to 256: a value below 16 acts as 16 and a value above 256 acts as 256.
- R3: valid_o is high for exactly one cycle per output word. In steady running, consecutive strobes are exactly OSR cycles apart. The first strobe of a run follows the edge that samples the run's OSR-th accepted bit.
- R4: Number the bits accepted since the last restart b[0], b[1], … (sampled on rising edges; bits before the run count as 0). Output word k (k = 0, 1, …) appears on the cycle after the edge that samples b[(k+1)·OSR−1]. Its value is y2[k] + y2[k−2], where y2[k] = Σ_{r=0}^{OSR−1} (OSR−r)·b[k·OSR+r] + Σ_{r=0}^{OSR−1} r·b[(k−1)·OSR+r], and y2 with a negative index is 0. The word is unsigned.
- R5: For an input with n ones in every block of OSR bits, the output word is 2·OSR·n once settled (2·OSR² for all ones).
- R6: After the density changes at a block boundary, the fourth output word whose block lies at or after the change equals the new settled value, and so do all later words. The third such word still differs whenever the old and new densities differ.
- R7: settled_o is 0 on the first three output words of a run and 1 from the fourth word on. It changes only with a strobe or a restart.
- R8: On any rising edge where the clamped osr_i differs from the active ratio, the filter restarts. The bit on that edge is discarded, all filter history is cleared, settled_o goes to 0 and no strobe is given. The next accepted bit is b[0] of the new run.
- R9: Between strobes, dout_o holds the last output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock; the bit is sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| osr_i | input | 9 | Requested oversampling ratio, clamped to 16..256 |
| bit_i | input | 1 | Modulator data bit |
| dout_o | output | 18 | Filter output word, unsigned |
| valid_o | output | 1 | One-cycle strobe for each new output word |
| settled_o | output | 1 | High when the current word's full filter history lies inside the run |

## Verification
On every cycle, the assertions check the following:
- the strobe is a single-cycle pulse, and successive strobes within a run are exactly the active ratio apart;
- the word holds between strobes;
- every word stays within 2·OSR²;
- the settled flag only drops on a restart;
- the active ratio stays inside the clamp range.

The exact numeric result of the weighted sums can only be shown by the bench's scenarios. So can the four-word settling after a density step, the clamp seen as output spacing, and the cleared history after a mid-block ratio change. The bench compares these against a behavioural model that recomputes each word from the stored bit history.

// File: rtl/sf_pkg.sv
package sf_pkg;
  // Number of integrator / differentiator pairs (sinc order before the fast term).
  localparam int SF_ORDER    = 2;
  // Output-rate lag of the added term (1 + z^-LAG at the decimated rate).
  localparam int SF_FAST_LAG = 2;
  // Output words needed before a word depends only on in-run bits.
  localparam int SF_SETTLE_WORDS = SF_ORDER + SF_FAST_LAG;
endpackage

// File: rtl/sf_rst_sync.sv
module sf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic q0_q;
  logic q1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q0_q <= 1'b0;
      q1_q <= 1'b0;
    end else begin
      q0_q <= 1'b1;
      q1_q <= q0_q;
    end
  end

  assign rst_s_n = q1_q;
endmodule

// File: rtl/sf_ctrl.sv
module sf_ctrl #(
  parameter int OSRW        = 9,
  parameter int OSR_MIN     = 16,
  parameter int OSR_MAX     = 256,
  parameter int SETTLE_LAST = 3,
  localparam int NW         = $clog2(SETTLE_LAST + 2)
) (
  input  logic            clk,
  input  logic            rst_s_n,
  input  logic [OSRW-1:0] osr_i,
  output logic [OSRW-1:0] osr_act,
  output logic            restart,
  output logic            tick,
  output logic            last_word
);
  logic [OSRW-1:0] osr_req;
  logic [OSRW-1:0] osr_q, osr_d;
  logic [OSRW-1:0] cnt_q, cnt_d;
  logic [NW-1:0]   nout_q, nout_d;

  // Next-state logic
  always_comb begin
    if (osr_i < OSRW'(OSR_MIN))      osr_req = OSRW'(OSR_MIN);
    else if (osr_i > OSRW'(OSR_MAX)) osr_req = OSRW'(OSR_MAX);
    else                             osr_req = osr_i;

    restart   = (osr_req != osr_q);
    tick      = !restart && (cnt_q == (osr_q - OSRW'(1)));
    last_word = (nout_q == NW'(SETTLE_LAST));

    osr_d  = restart ? osr_req : osr_q;
    cnt_d  = (restart || tick) ? '0 : cnt_q + OSRW'(1);
    nout_d = nout_q;
    if (restart)                 nout_d = '0;
    else if (tick && !last_word) nout_d = nout_q + NW'(1);
  end

  // Registers; the ratio resets to 0 so the first running edge always loads it
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      osr_q  <= '0;
      cnt_q  <= '0;
      nout_q <= '0;
    end else begin
      osr_q  <= osr_d;
      cnt_q  <= cnt_d;
      nout_q <= nout_d;
    end
  end

  assign osr_act = osr_q;
endmodule

// File: rtl/sf_integ.sv
module sf_integ #(
  parameter int W     = 18,
  parameter int ORDER = 2
) (
  input  logic         clk,
  input  logic         rst_s_n,
  input  logic         clr,
  input  logic         en,
  input  logic         bit_i,
  output logic [W-1:0] sum_n
);
  logic [W-1:0] acc_q [ORDER];
  logic [W-1:0] acc_n [ORDER];
  logic [W-1:0] feed  [ORDER+1];

  assign feed[0] = {{(W-1){1'b0}}, bit_i};

  // Cascaded running sums; each stage adds the updated value of the one before,
  // so the final next value includes the bit of the current edge.
  for (genvar j = 0; j < ORDER; j++) begin : g_stage
    assign acc_n[j]  = acc_q[j] + feed[j];
    assign feed[j+1] = acc_n[j];

    always_ff @(posedge clk or negedge rst_s_n) begin
      if (!rst_s_n)  acc_q[j] <= '0;
      else if (clr)  acc_q[j] <= '0;
      else if (en)   acc_q[j] <= acc_n[j];
    end
  end

  assign sum_n = acc_n[ORDER-1];
endmodule

// File: rtl/sf_comb.sv
module sf_comb #(
  parameter int W     = 18,
  parameter int ORDER = 2,
  parameter int LAG   = 2
) (
  input  logic         clk,
  input  logic         rst_s_n,
  input  logic         clr,
  input  logic         tick,
  input  logic         settled_in,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         valid,
  output logic         settled
);
  logic [W-1:0] prev_q [ORDER];
  logic [W-1:0] stage  [ORDER+1];
  logic [W-1:0] hist_q [LAG];
  logic [W-1:0] y2;
  logic [W-1:0] y_full;
  logic [W-1:0] dout_q, dout_d;
  logic         valid_q;
  logic         settled_q, settled_d;

  assign stage[0] = din;

  // Output-rate differences
  for (genvar j = 0; j < ORDER; j++) begin : g_diff
    assign stage[j+1] = stage[j] - prev_q[j];

    always_ff @(posedge clk or negedge rst_s_n) begin
      if (!rst_s_n)   prev_q[j] <= '0;
      else if (clr)   prev_q[j] <= '0;
      else if (tick)  prev_q[j] <= stage[j];
    end
  end

  assign y2 = stage[ORDER];

  // History of sinc^2 words for the added term
  for (genvar i = 0; i < LAG; i++) begin : g_hist
    always_ff @(posedge clk or negedge rst_s_n) begin
      if (!rst_s_n)   hist_q[i] <= '0;
      else if (clr)   hist_q[i] <= '0;
      else if (tick)  hist_q[i] <= (i == 0) ? y2 : hist_q[(i == 0) ? 0 : i-1];
    end
  end

  always_comb begin
    y_full    = y2 + hist_q[LAG-1];
    dout_d    = tick ? y_full : dout_q;
    settled_d = settled_q;
    if (clr)       settled_d = 1'b0;
    else if (tick) settled_d = settled_in;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      dout_q    <= '0;
      valid_q   <= 1'b0;
      settled_q <= 1'b0;
    end else begin
      dout_q    <= dout_d;
      valid_q   <= tick;
      settled_q <= settled_d;
    end
  end

  assign dout    = dout_q;
  assign valid   = valid_q;
  assign settled = settled_q;
endmodule

// File: rtl/sincfast_decim.sv
module sincfast_decim
  import sf_pkg::*;
#(
  parameter int OSR_LOG2_MAX = 8,
  parameter int OSR_MIN      = 16,
  parameter int ORDER        = SF_ORDER,
  parameter int FAST_LAG     = SF_FAST_LAG,
  localparam int OSRW        = OSR_LOG2_MAX + 1,
  localparam int W           = ORDER * OSR_LOG2_MAX + 2,
  localparam int OSR_MAX     = 1 << OSR_LOG2_MAX
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OSRW-1:0] osr_i,
  input  logic            bit_i,
  output logic [W-1:0]    dout_o,
  output logic            valid_o,
  output logic            settled_o
);
  logic            rst_s_n;
  logic [OSRW-1:0] osr_act;
  logic            restart;
  logic            tick;
  logic            last_word;
  logic [W-1:0]    sum_n;

  sf_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  sf_ctrl #(
    .OSRW        (OSRW),
    .OSR_MIN     (OSR_MIN),
    .OSR_MAX     (OSR_MAX),
    .SETTLE_LAST (ORDER + FAST_LAG - 1)
  ) u_ctrl (
    .clk       (clk),
    .rst_s_n   (rst_s_n),
    .osr_i     (osr_i),
    .osr_act   (osr_act),
    .restart   (restart),
    .tick      (tick),
    .last_word (last_word)
  );

  sf_integ #(
    .W     (W),
    .ORDER (ORDER)
  ) u_integ (
    .clk     (clk),
    .rst_s_n (rst_s_n),
    .clr     (restart),
    .en      (!restart),
    .bit_i   (bit_i),
    .sum_n   (sum_n)
  );

  sf_comb #(
    .W     (W),
    .ORDER (ORDER),
    .LAG   (FAST_LAG)
  ) u_comb (
    .clk        (clk),
    .rst_s_n    (rst_s_n),
    .clr        (restart),
    .tick       (tick),
    .settled_in (last_word),
    .din        (sum_n),
    .dout       (dout_o),
    .valid      (valid_o),
    .settled    (settled_o)
  );
endmodule

// File: rtl/sincfast_decim_chk.sv
module sincfast_decim_chk #(
  parameter int OSRW    = 9,
  parameter int W       = 18,
  parameter int OSR_MIN = 16,
  parameter int OSR_MAX = 256
) (
  input logic            clk,
  input logic            rst_n,
  input logic [OSRW-1:0] osr_act,
  input logic            restart,
  input logic            valid_o,
  input logic [W-1:0]    dout_o,
  input logic            settled_o
);
  logic [OSRW:0] gap_q;
  logic          have_q;
  int            lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      have_q <= 1'b0;
    end else begin
      if (valid_o) gap_q <= (OSRW+1)'(1);
      else         gap_q <= gap_q + (OSRW+1)'(1);
      if (restart)      have_q <= 1'b0;
      else if (valid_o) have_q <= 1'b1;
    end
  end

  always_comb lim = 2 * int'(osr_act) * int'(osr_act);

  // R3
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R3
  valid_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && have_q) |-> (gap_q == {1'b0, osr_act}));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(dout_o));

  // R5
  word_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (int'(dout_o) <= lim));

  // R8
  settled_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(settled_o) |-> $past(restart));

  // R2
  osr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (int'(osr_act) >= OSR_MIN && int'(osr_act) <= OSR_MAX));
endmodule

bind sincfast_decim sincfast_decim_chk #(
  .OSRW    (OSRW),
  .W       (W),
  .OSR_MIN (OSR_MIN),
  .OSR_MAX (OSR_MAX)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .osr_act   (osr_act),
  .restart   (restart),
  .valid_o   (valid_o),
  .dout_o    (dout_o),
  .settled_o (settled_o)
);

// File: tb/sincfast_decim_bench.sv
module sincfast_decim_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  osr_i = 9'd16;
  logic        bit_i = 1'b0;
  logic [17:0] dout_o;
  logic        valid_o;
  logic        settled_o;

  always #10 clk = ~clk;

  sincfast_decim u_sincfast_decim (
    .clk       (clk),
    .rst_n     (rst_n),
    .osr_i     (osr_i),
    .bit_i     (bit_i),
    .dout_o    (dout_o),
    .valid_o   (valid_o),
    .settled_o (settled_o)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // Behavioural model state
  int m_edges;
  int m_act;
  int m_bits[$];
  int m_y2[$];
  int e_dout;
  bit e_valid;
  bit e_settled;
  bit m_inrst;

  // Observed output words of the current run
  int obs_d[$];
  bit obs_s[$];
  int obs_t[$];
  int cyc = 0;

  function automatic int clampv(int v);
    if (v < 16)  return 16;
    if (v > 256) return 256;
    return v;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_edges = 0; m_act = 0;
    m_bits.delete(); m_y2.delete();
    e_dout = 0; e_valid = 0; e_settled = 0; m_inrst = 1;
  endtask

  // Predicts the effect of the next rising edge for the inputs now driven
  task automatic predict(bit b, int osr);
    int c, k, base, y2, y;
    if (!rst_n) return;
    m_edges++;
    if (m_edges <= 2) return;
    m_inrst = 0;
    c = clampv(osr);
    e_valid = 0;
    if (c != m_act) begin
      m_act = c; m_bits.delete(); m_y2.delete(); e_settled = 0;
    end else begin
      m_bits.push_back(int'(b));
      if (m_bits.size() % m_act == 0) begin
        k = m_bits.size() / m_act - 1;
        base = k * m_act;
        y2 = 0;
        for (int r = 0; r < m_act; r++) begin
          y2 += (m_act - r) * m_bits[base + r];
          if (k >= 1) y2 += r * m_bits[base - m_act + r];
        end
        m_y2.push_back(y2);
        y = y2 + ((k >= 2) ? m_y2[k-2] : 0);
        e_dout = y; e_valid = 1; e_settled = (k >= 3);
      end
    end
  endtask

  task automatic sample();
    @(negedge clk);
    cyc++;
    check(valid_o == e_valid, m_inrst ? "R1" : "R3", "valid_o", int'(valid_o), int'(e_valid));
    check(int'(dout_o) == e_dout, m_inrst ? "R1" : (e_valid ? "R4" : "R9"), "dout_o",
          int'(dout_o), e_dout);
    check(settled_o == e_settled, m_inrst ? "R1" : "R7", "settled_o",
          int'(settled_o), int'(e_settled));
    if (valid_o) begin
      obs_d.push_back(int'(dout_o));
      obs_s.push_back(settled_o);
      obs_t.push_back(cyc);
    end
  endtask

  task automatic drive(bit b, int osr);
    bit_i = b;
    osr_i = osr[8:0];
    predict(b, osr);
  endtask

  task automatic do_reset(int n);
    sample();
    rst_n = 1'b0;
    model_reset();
    drive(1'b0, 16);
    repeat (n) begin
      sample();
      drive(1'b0, 16);
    end
    check(valid_o == 0 && dout_o == 0 && settled_o == 0, "R1", "outputs in reset",
          int'(dout_o), 0);
    rst_n = 1'b1;
    m_edges = 0;
    drive(1'b0, 16);
  endtask

  // n ones per block (first n positions), switching n1 -> n2 at block step; rnd = random bits
  task automatic run(int osr, int n1, int n2, int step, int nblk, bit rnd);
    int blk, r, n;
    bit b;
    obs_d.delete(); obs_s.delete(); obs_t.delete();
    do begin
      sample();
      b = 0;
      if (m_act != 0 && clampv(osr) == m_act) begin
        blk = m_bits.size() / m_act;
        r   = m_bits.size() % m_act;
        n   = (blk < step) ? n1 : n2;
        b   = rnd ? bit'($urandom_range(1, 0)) : (r < n);
      end
      drive(b, osr);
    end while (obs_d.size() < nblk);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    model_reset();
    drive(1'b0, 16);
    do_reset(3);

    // R1: outputs stay 0 through the synchronizer edges
    sample(); drive(1'b1, 16);
    sample(); drive(1'b1, 16);
    check(valid_o == 0 && dout_o == 0, "R1", "dout after release", int'(dout_o), 0);

    // All ones at OSR 16
    run(16, 16, 16, 0, 6, 0);
    check(obs_d[0] == 136, "R4", "first word all ones", obs_d[0], 136);
    check(obs_d[3] == 512, "R5", "settled all ones", obs_d[3], 512);
    check(obs_s[2] == 0, "R7", "third word flag", int'(obs_s[2]), 0);
    check(obs_s[3] == 1, "R7", "fourth word flag", int'(obs_s[3]), 1);
    check(obs_t[5] - obs_t[4] == 16, "R3", "strobe spacing", obs_t[5] - obs_t[4], 16);

    // Density step at block 5, OSR 32: 8 -> 24 ones per block
    run(32, 8, 24, 5, 12, 0);
    check(obs_d[4] == 512, "R5", "settled before step", obs_d[4], 512);
    check(obs_d[7] != 1536, "R6", "third word after step still moving", obs_d[7], 1536);
    check(obs_d[8] == 1536, "R6", "fourth word after step", obs_d[8], 1536);
    check(obs_d[11] == 1536, "R6", "later word after step", obs_d[11], 1536);

    // Clamp above and below
    run(300, 100, 100, 0, 5, 0);
    check(obs_d[4] == 51200, "R2", "clamped to 256 value", obs_d[4], 51200);
    check(obs_t[4] - obs_t[3] == 256, "R2", "clamped to 256 spacing", obs_t[4] - obs_t[3], 256);
    run(5, 3, 3, 0, 5, 0);
    check(obs_d[4] == 96, "R2", "clamped to 16 value", obs_d[4], 96);
    check(obs_t[4] - obs_t[3] == 16, "R2", "clamped to 16 spacing", obs_t[4] - obs_t[3], 16);

    // Random bits, exact weighted sums against the model each cycle
    run(64, 0, 0, 0, 8, 1);

    // Ratio change one bit into a block restarts from empty
    run(48, 48, 48, 0, 5, 0);
    check(obs_s[4] == 1, "R7", "settled before change", int'(obs_s[4]), 1);
    run(40, 40, 40, 0, 2, 0);
    check(obs_s[0] == 0, "R8", "flag cleared on restart", int'(obs_s[0]), 0);
    check(obs_d[0] == 820, "R8", "history cleared on restart", obs_d[0], 820);

    // Reset in the middle of a run
    run(20, 0, 0, 0, 3, 1);
    do_reset(2);
    run(16, 4, 4, 0, 5, 0);
    check(obs_d[4] == 128, "R5", "after mid-run reset", obs_d[4], 128);

    summary();
    done = 1;
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule